// File: doc/BRIEF.md
# ADC Sequencer Trigger and FIFO Unit

This block is the digital back end of a four-sequencer analog-to-digital converter. Each sequencer owns a small result FIFO. A one-cycle pulse on the trigger input, normally driven by a timer, writes one new sample into every sequencer that is switched on and whose event source is set to the timer code. A pseudo-random noise generator stands in for the analog input: it advances once per written sample, and a few of its bits form the sample value.

Software reaches the unit through a simple register bus. Reads are combinational from the address. A read cycle on a sequencer's data register also removes the oldest entry at the clock edge. Each sequencer has an interrupt output that is driven by a raw pending bit gated by a mask bit. Sticky overflow and underflow bits record samples that were dropped and reads that found the FIFO empty.

Top module: `adc_seq_fifo`

## Requirements
- R1: After reset, the status word of every sequencer reads 0x100 (empty only). The enable, raw-pending, mask, overflow and underflow registers read 0, and all interrupt outputs are low.
- R2: On a trigger, sequencer n receives a sample only if enable bit n (register 0x00, bits 3:0) is set and its 4-bit event field (register 0x14, bits 4n+3:4n) holds 5. Any other code, or a clear enable bit, leaves its FIFO untouched.
- R3: The status word at 0x4C+0x20n shows the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. A sample write stores at the write pointer, advances it modulo 16 and clears empty. Full is set when the advanced write pointer equals the read pointer.
- R4: A sample for a full FIFO is discarded, the pointers and flags do not change, and overflow bit n (register 0x10) is set.
- R5: A read of 0x48+0x20n returns the entry at the read pointer and then advances that pointer modulo 16 and clears full. Empty is set when the advanced read pointer equals the write pointer.
- R6: A read of the data register while the FIFO is empty returns the stale entry at the read pointer, leaves the pointers and flags unchanged, and sets underflow bit n (register 0x18).
- R7: The 32-bit noise state starts at 0. It advances as state*314159+1 once for each sequencer that receives a sample, taken in ascending sequencer order. The sample is 0x200 plus bits 18:16 of the advanced state. The state does not advance on a trigger that selects no sequencer.
- R8: Every sequencer selected by a trigger sets raw bit n (register 0x04, read-only), including when its sample is discarded. Output irq[n] equals raw bit n AND mask bit n (register 0x08, bits 3:0). Register 0x0C reads raw AND mask, and writing 1 to a bit there clears that raw bit.
- R9: Register writes keep only the implemented bits. The mux register at 0x40+0x20n keeps the bits under 0x33333333, the control register at 0x44+0x20n keeps all 32 bits, and the event register keeps 16 bits.
- R10: Writing 1 to a bit of the overflow or underflow register clears that bit. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data-register read removes an entry |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| trig | input | 1 | Timer trigger; each high cycle is one trigger |
| irq | output | 4 | Per-sequencer interrupt |

## Verification
The bench builds the unit with its default values: four sequencers, 16-entry FIFOs and 10-bit samples. With these values both pointers wrap through zero in under twenty triggers, so the full and empty flags are reached with the pointers equal at a non-zero position. A dropped sample and a stale read after a wrap also fall within a short run. Two sequencers fire on the same trigger, which exposes the order in which the noise state advances. A trigger that selects no sequencer is shown not to advance the noise state.

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int NUM_SEQ = 4,
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 10,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               trig,
  output logic [NUM_SEQ-1:0] irq
);
  localparam int PW         = $clog2(DEPTH);
  localparam int SW         = $clog2(NUM_SEQ);
  localparam int EV_W       = 4 * NUM_SEQ;
  localparam int SEQ_BASE   = 'h40;
  localparam int SEQ_STRIDE = 'h20;
  localparam logic [3:0] EV_TIMER = 4'd5;

  logic [NUM_SEQ-1:0] enable_q, raw_q, mask_q, ovf_q, unf_q;
  logic [EV_W-1:0]    evsel_q;
  logic [31:0]        noise_q, nz;
  logic [NUM_SEQ-1:0] sel_v, pop_v, full_v, empty_v;
  logic [NUM_SEQ-1:0][DATA_W-1:0] samp, head_w;
  logic [NUM_SEQ-1:0][31:0]       stat_w, mux_w, ctl_w;

  logic [ADDR_W-1:0] seq_off;
  logic [SW-1:0]     seq_idx;
  logic [4:0]        sub;
  logic              seq_hit, glob_wr;

  assign seq_off = bus_addr - ADDR_W'(SEQ_BASE);
  assign seq_idx = seq_off[5 +: SW];
  assign sub     = seq_off[4:0];
  assign seq_hit = (bus_addr >= ADDR_W'(SEQ_BASE)) &&
                   (bus_addr <  ADDR_W'(SEQ_BASE + SEQ_STRIDE * NUM_SEQ));
  assign glob_wr = bus_wr && (bus_addr < ADDR_W'(SEQ_BASE));
  assign irq     = raw_q & mask_q;

  always_comb begin
    nz = noise_q;
    for (int n = 0; n < NUM_SEQ; n++) begin
      if (sel_v[n]) nz = nz * 32'd314159 + 32'd1;
      samp[n] = DATA_W'(32'h200 + {29'd0, nz[18:16]});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0; raw_q <= '0; mask_q <= '0;
      ovf_q <= '0; unf_q <= '0; evsel_q <= '0; noise_q <= '0;
    end else begin
      noise_q <= nz;
      if (glob_wr && bus_addr == ADDR_W'('h00)) enable_q <= bus_wdata[NUM_SEQ-1:0];
      if (glob_wr && bus_addr == ADDR_W'('h08)) mask_q   <= bus_wdata[NUM_SEQ-1:0];
      if (glob_wr && bus_addr == ADDR_W'('h14)) evsel_q  <= bus_wdata[EV_W-1:0];
      raw_q <= (raw_q & ~((glob_wr && bus_addr == ADDR_W'('h0C)) ? bus_wdata[NUM_SEQ-1:0] : '0))
             | sel_v;
      ovf_q <= (ovf_q & ~((glob_wr && bus_addr == ADDR_W'('h10)) ? bus_wdata[NUM_SEQ-1:0] : '0))
             | (sel_v & full_v);
      unf_q <= (unf_q & ~((glob_wr && bus_addr == ADDR_W'('h18)) ? bus_wdata[NUM_SEQ-1:0] : '0))
             | (pop_v & empty_v);
    end
  end

  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
    logic [PW-1:0]     rp_q, wp_q;
    logic              empty_q, full_q, do_push, do_pop, here_wr;
    logic [31:0]       mux_q, ctl_q;
    logic [DATA_W-1:0] mem [DEPTH];

    assign sel_v[n]   = trig && enable_q[n] && (evsel_q[4*n +: 4] == EV_TIMER);
    assign pop_v[n]   = bus_rd && seq_hit && (seq_idx == SW'(n)) && (sub == 5'h08);
    assign here_wr    = bus_wr && seq_hit && (seq_idx == SW'(n));
    assign do_push    = sel_v[n] && !full_q;
    assign do_pop     = pop_v[n] && !empty_q;
    assign full_v[n]  = full_q;
    assign empty_v[n] = empty_q;
    assign head_w[n]  = mem[rp_q];
    assign mux_w[n]   = mux_q;
    assign ctl_w[n]   = ctl_q;
    assign stat_w[n]  = {19'd0, full_q, 3'd0, empty_q, 4'(wp_q), 4'(rp_q)};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp_q <= '0; wp_q <= '0; empty_q <= 1'b1; full_q <= 1'b0;
        mux_q <= '0; ctl_q <= '0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
        if (here_wr && sub == 5'h00) mux_q <= bus_wdata & 32'h3333_3333;
        if (here_wr && sub == 5'h04) ctl_q <= bus_wdata;
        if (do_push) begin
          mem[wp_q] <= samp[n];
          wp_q      <= wp_q + 1'b1;
        end
        if (do_pop) rp_q <= rp_q + 1'b1;
        if (do_push && !do_pop) begin
          empty_q <= 1'b0;
          full_q  <= (PW'(wp_q + 1'b1) == rp_q);
        end else if (do_pop && !do_push) begin
          full_q  <= 1'b0;
          empty_q <= (PW'(rp_q + 1'b1) == wp_q);
        end
      end
    end

    // R3
    no_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));
    // R4
    drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[n] && full_q && !pop_v[n]) |=> (full_q && $stable(wp_q) && ovf_q[n]));
    // R6
    underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_v[n] && empty_q && !sel_v[n]) |=> (empty_q && $stable(rp_q) && unf_q[n]));
    // R8
    raw_on_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_v[n] |=> raw_q[n]);
  end

  always_comb begin
    bus_rdata = '0;
    if (seq_hit) begin
      case (sub)
        5'h00:   bus_rdata = mux_w[seq_idx];
        5'h04:   bus_rdata = ctl_w[seq_idx];
        5'h08:   bus_rdata = 32'(head_w[seq_idx]);
        5'h0C:   bus_rdata = stat_w[seq_idx];
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        ADDR_W'('h00): bus_rdata = 32'(enable_q);
        ADDR_W'('h04): bus_rdata = 32'(raw_q);
        ADDR_W'('h08): bus_rdata = 32'(mask_q);
        ADDR_W'('h0C): bus_rdata = 32'(raw_q & mask_q);
        ADDR_W'('h10): bus_rdata = 32'(ovf_q);
        ADDR_W'('h14): bus_rdata = 32'(evsel_q);
        ADDR_W'('h18): bus_rdata = 32'(unf_q);
        default:       bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/test_adc_seq_fifo.sv
module test_adc_seq_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  logic [31:0] bn = '0;
  logic [31:0] exp_q [16];
  logic [31:0] d, sa, sb;

  always #10 clk = ~clk;

  adc_seq_fifo i_adc_seq_fifo (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig(trig), .irq(irq));

  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_000F},
    {8'h40, 32'hFFFF_FFFF, 32'h3333_3333},
    {8'h80, 32'h1234_5678, 32'h1230_1230},
    {8'h64, 32'hABCD_1234, 32'hABCD_1234},
    {8'h14, 32'hFFFF_5555, 32'h0000_5555},
    {8'h08, 32'h0000_00FF, 32'h0000_000F},
    {8'h10, 32'h0000_000F, 32'h0000_0000},
    {8'h04, 32'h0000_000F, 32'h0000_0000}
  };

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step();
    bn = bn * 32'd314159 + 32'd1;
    return 32'h200 + {29'd0, bn[18:16]};
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #2; v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'h4C + 8'(s * 32), d); check("R1 status", d, 32'h100);
    end
    rd(8'h04, d); check("R1 raw", d, 0);
    rd(8'h00, d); check("R1 enable", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R9 R10 R8 register table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      check("R9 table", d, VEC[i][31:0]);
    end

    // R2 R7 two sequencers on one trigger
    wr(8'h00, 32'h5);
    wr(8'h14, 32'h0555);
    wr(8'h08, 32'h1);
    pulse();
    sa = step(); sb = step();
    rd(8'h4C, d); check("R3 seq0 status", d, 32'h010);
    rd(8'h6C, d); check("R2 seq1 disabled", d, 32'h100);
    rd(8'h8C, d); check("R3 seq2 status", d, 32'h010);
    rd(8'hAC, d); check("R2 seq3 code", d, 32'h100);
    rd(8'h04, d); check("R8 raw", d, 32'h5);
    check("R8 irq", 32'(irq), 32'h1);
    rd(8'h0C, d); check("R8 masked", d, 32'h1);
    rd(8'h48, d); check("R7 seq0 sample", d, sa);
    rd(8'h88, d); check("R7 seq2 sample", d, sb);
    rd(8'h4C, d); check("R5 empty again", d, 32'h111);

    // R6 underflow
    rd(8'h48, d); check("R6 stale data", d, 0);
    rd(8'h4C, d); check("R6 status held", d, 32'h111);
    rd(8'h18, d); check("R6 underflow bit", d, 32'h1);
    wr(8'h18, 32'h0); rd(8'h18, d); check("R10 write 0 keeps", d, 32'h1);
    wr(8'h18, 32'h1); rd(8'h18, d); check("R10 underflow clear", d, 0);
    wr(8'h0C, 32'h5); rd(8'h04, d); check("R8 clear raw", d, 0);
    check("R8 irq low", 32'(irq), 0);

    // R3 R4 fill to full, then drop
    wr(8'h00, 32'h1);
    for (int i = 0; i < 16; i++) begin
      pulse(); exp_q[i] = step();
    end
    rd(8'h4C, d); check("R3 full", d, 32'h1011);
    pulse(); void'(step());
    rd(8'h4C, d); check("R4 status held", d, 32'h1011);
    rd(8'h10, d); check("R4 overflow bit", d, 32'h1);
    rd(8'h04, d); check("R8 raw on drop", d, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(8'h48, d); check("R5 drain", d, exp_q[i]);
    end
    rd(8'h4C, d); check("R5 drained", d, 32'h111);
    rd(8'h48, d); check("R6 stale after wrap", d, exp_q[0]);
    wr(8'h10, 32'h1); rd(8'h10, d); check("R10 overflow clear", d, 0);

    // R2 R7 non-timer code: no push, no noise step
    wr(8'h14, 32'h0550);
    wr(8'h0C, 32'hF);
    pulse();
    rd(8'h4C, d); check("R2 other code", d, 32'h111);
    rd(8'h04, d); check("R2 no raw", d, 0);
    wr(8'h14, 32'h0555);
    pulse(); sa = step();
    rd(8'h48, d); check("R7 noise not advanced", d, sa);

    report();
    $finish;
  end
endmodule